// File: doc/BRIEF.md
# One-Time-Programmable Shadowed Parameter Bank

This block stores the configuration words of a sensor device. It has sixteen 16-bit fuse-style words that can each be programmed only once. In front of them sits a working bank of sixteen 16-bit volatile words. After a reset, a loader walks through the fuse words and copies each one into its working counterpart. The one exception is the device identity word, which is not copied. When the walk is complete, the block raises a ready flag. From then on, the rest of the device uses only the working bank, so the host can change a setting on the fly and the change takes effect at once.

The host reaches the block through a 5-bit word-addressed port. Bit 4 of the address selects the area: 0 for the fuse words (0–15), 1 for the working bank (16–31). The low four bits pick the index, and index n in one area matches index n in the other. A write changes one working word. A burn command programs the fuse word at the addressed index from the current working value, with bit 0 set as a marker that the word has been burned, and the working copy picks up the same marker. Bit 15 of each working word is that word's lock. A refused request raises a one-cycle error strobe and changes nothing.

Indices 8–15 hold identification and factory words. The host can only read them.

Top module: `cfg_bank_top`

## Requirements
- R1: After `rst_n` is released, `ready` is low for exactly 15 rising edges and high from the 16th. While `ready` is low, write and burn requests are ignored: no word changes and `err_pulse` stays low.
- R2: When loading completes, working word i holds fuse word i for every index except 15, the identity word. Working word 15 reads 0, and fuse word 15 reads the `CHIP_ID` parameter.
- R3: `rd_data` follows `req_addr` combinationally. Addresses 0–15 return fuse word `addr[3:0]` and addresses 16–31 return working word `addr[3:0]`. At power-on, fuse words 0–7 are 0, fuse words 8–14 are {index[3:0], 8'hC3, 4'h1}, and fuse word 15 is `CHIP_ID`.
- R4: A write to an address in 16–23 whose working word has bit 15 clear replaces that working word with `req_wdata`. The new value is readable in the next cycle.
- R5: A write or a burn aimed at an index whose working word has bit 15 (the lock) set is refused.
- R6: An accepted burn at index i (0–7, from either area) sets fuse word i and working word i both to (working word i | 16'h0001).
- R7: A burn at an index whose fuse word already has bit 0 set is refused, and that fuse word keeps its value.
- R8: Writes to addresses 0–15 or 24–31 are refused, and so are burns at indices 8–15.
- R9: Each refused request produces `err_pulse` high in exactly the following cycle and leaves every word unchanged. The burn bit takes priority over the write bit.
- R10: A request with `req_valid` high and both `req_write` and `req_burn` low never raises `err_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset of the fuse model, active low |
| rst_n | input | 1 | Reset of the working bank and loader, active low |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | Request is a write of a working word |
| req_burn | input | 1 | Request is a burn of a fuse word |
| req_addr | input | 5 | Word address: bit 4 selects the area, bits 3:0 the index |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data for `req_addr` |
| ready | output | 1 | Loading from the fuse words is complete |
| err_pulse | output | 1 | One-cycle strobe for a refused request |

## Verification
A fault in the working bank is visible on `rd_data` as soon as the affected address is presented, so the bench sweeps all 32 addresses after each group of operations. A wrong decision on the lock or fuse state appears one cycle after the request, as a wrong `err_pulse` or as an unexpected change in one of the two copies. A loader that is off by one in its count or its index shows up as a `ready` edge on the wrong cycle, or as a misplaced word right after a reset that leaves the fuse model intact.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int NREG      = 16;
  localparam int W         = 16;
  localparam int IDXW      = $clog2(NREG);
  localparam int AW        = IDXW + 1;
  localparam int LOCK_BIT  = W - 1;
  localparam int FUSE_BIT  = 0;
  localparam int HOST_REGS = NREG / 2;
  localparam int ID_IDX    = NREG - 1;

  typedef logic [W-1:0]    word_t;
  typedef logic [IDXW-1:0] idx_t;

  // power-on content of the fuse model
  function automatic word_t factory_word(int i, word_t chip_id);
    if (i == ID_IDX)    return chip_id;
    if (i >= HOST_REGS) return {4'(i), 8'hC3, 4'h1};
    return '0;
  endfunction

  function automatic word_t fuse_mark(word_t v);
    return v | (word_t'(1) << FUSE_BIT);
  endfunction

  function automatic logic host_editable(idx_t i);
    return int'(i) < HOST_REGS;
  endfunction

  function automatic logic is_locked(word_t v);
    return v[LOCK_BIT];
  endfunction
endpackage

// File: rtl/cfg_otp_store.sv
module cfg_otp_store
  import cfg_bank_pkg::*;
#(
  parameter word_t CHIP_ID = 16'hB7E5
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 prog_en,
  input  idx_t                 prog_idx,
  input  word_t                prog_data,
  output word_t [NREG-1:0]     words,
  output logic                 prog_fire
);
  // the write-once rule is kept here as well as in the controller
  assign prog_fire = prog_en && !words[prog_idx][FUSE_BIT];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < NREG; i++) words[i] <= factory_word(i, CHIP_ID);
    end else if (prog_fire) begin
      words[prog_idx] <= prog_data;
    end
  end
endmodule

// File: rtl/cfg_mirror.sv
module cfg_mirror
  import cfg_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  word_t [NREG-1:0] otp_words,
  input  logic             wr_en,
  input  idx_t             wr_idx,
  input  word_t            wr_data,
  output word_t [NREG-1:0] words,
  output logic             ready,
  output logic             load_fire,
  output idx_t             load_idx
);
  logic [IDXW:0] cnt;

  assign ready     = cnt[IDXW];
  assign load_idx  = cnt[IDXW-1:0];
  assign load_fire = !ready && (load_idx != idx_t'(ID_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      words <= '0;
    end else begin
      if (!ready) cnt <= cnt + 1'b1;
      if (load_fire)           words[load_idx] <= otp_words[load_idx];
      else if (wr_en && ready) words[wr_idx]   <= wr_data;
    end
  end
endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
  import cfg_bank_pkg::*;
(
  input  logic             ready,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_burn,
  input  logic [AW-1:0]    req_addr,
  input  word_t            req_wdata,
  input  word_t [NREG-1:0] mir_words,
  input  word_t [NREG-1:0] otp_words,
  output logic             mir_wr_en,
  output logic             otp_prog_en,
  output idx_t             tgt_idx,
  output word_t            tgt_data,
  output logic             refuse
);
  logic vol_area;
  logic burn_ok;
  logic write_ok;

  assign tgt_idx  = req_addr[IDXW-1:0];
  assign vol_area = req_addr[IDXW];
  assign burn_ok  = host_editable(tgt_idx) && !is_locked(mir_words[tgt_idx])
                    && !otp_words[tgt_idx][FUSE_BIT];
  assign write_ok = vol_area && host_editable(tgt_idx) && !is_locked(mir_words[tgt_idx]);

  always_comb begin
    mir_wr_en   = 1'b0;
    otp_prog_en = 1'b0;
    refuse      = 1'b0;
    tgt_data    = req_wdata;
    if (ready && req_valid) begin
      if (req_burn) begin
        if (burn_ok) begin
          otp_prog_en = 1'b1;
          mir_wr_en   = 1'b1;
          tgt_data    = fuse_mark(mir_words[tgt_idx]);
        end else begin
          refuse = 1'b1;
        end
      end else if (req_write) begin
        if (write_ok) mir_wr_en = 1'b1;
        else          refuse    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_bank_top.sv
module cfg_bank_top
  import cfg_bank_pkg::*;
#(
  parameter logic [15:0] CHIP_ID = 16'hB7E5
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_burn,
  input  logic [4:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic [15:0] rd_data,
  output logic        ready,
  output logic        err_pulse
);
  word_t [NREG-1:0] otp_words;
  word_t [NREG-1:0] mir_words;
  logic             mir_wr_en;
  logic             otp_prog_en;
  logic             otp_prog_fire;
  idx_t             tgt_idx;
  word_t            tgt_data;
  logic             refuse;
  logic             load_fire;
  idx_t             load_idx;

  cfg_access_ctrl u_ctrl (
    .ready      (ready),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_burn   (req_burn),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mir_words  (mir_words),
    .otp_words  (otp_words),
    .mir_wr_en  (mir_wr_en),
    .otp_prog_en(otp_prog_en),
    .tgt_idx    (tgt_idx),
    .tgt_data   (tgt_data),
    .refuse     (refuse)
  );

  cfg_otp_store #(.CHIP_ID(CHIP_ID)) u_otp (
    .clk      (clk),
    .por_n    (por_n),
    .prog_en  (otp_prog_en),
    .prog_idx (tgt_idx),
    .prog_data(tgt_data),
    .words    (otp_words),
    .prog_fire(otp_prog_fire)
  );

  cfg_mirror u_mir (
    .clk      (clk),
    .rst_n    (rst_n),
    .otp_words(otp_words),
    .wr_en    (mir_wr_en),
    .wr_idx   (tgt_idx),
    .wr_data  (tgt_data),
    .words    (mir_words),
    .ready    (ready),
    .load_fire(load_fire),
    .load_idx (load_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_pulse <= 1'b0;
    else        err_pulse <= refuse;
  end

  assign rd_data = req_addr[IDXW] ? mir_words[req_addr[IDXW-1:0]]
                                  : otp_words[req_addr[IDXW-1:0]];
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk
  import cfg_bank_pkg::*;
(
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             ready,
  input logic             err_pulse,
  input logic             otp_prog_fire,
  input idx_t             tgt_idx,
  input word_t            tgt_data,
  input word_t [NREG-1:0] otp_words,
  input word_t [NREG-1:0] mir_words
);
  p_ready_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  p_quiet_loading_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !err_pulse);

  p_id_not_copied_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> mir_words[ID_IDX] == '0);

  p_burn_lands_r6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    otp_prog_fire |=> otp_words[$past(tgt_idx)] == $past(tgt_data));

  p_burn_marked_r6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    otp_prog_fire |-> tgt_data[FUSE_BIT]);

  for (genvar i = 0; i < NREG; i++) begin : g_word
    p_write_once_r7: assert property (@(posedge clk) disable iff (!por_n)
      otp_words[i][FUSE_BIT] |=> $stable(otp_words[i]));

    p_lock_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && mir_words[i][LOCK_BIT]) |=> $stable(mir_words[i]));

    if (i >= HOST_REGS) begin : g_ro
      p_ro_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> $stable(mir_words[i]));
    end
  end
endmodule

bind cfg_bank_top cfg_bank_chk u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .rst_n        (rst_n),
  .ready        (ready),
  .err_pulse    (err_pulse),
  .otp_prog_fire(otp_prog_fire),
  .tgt_idx      (tgt_idx),
  .tgt_data     (tgt_data),
  .otp_words    (otp_words),
  .mir_words    (mir_words)
);

// File: tb/cfg_bank_top_tb.sv
`timescale 1ns/1ps
module cfg_bank_top_tb;
  localparam logic [15:0] CHIP_ID = 16'hB7E5;
  localparam int OP_READ = 0, OP_WRITE = 1, OP_BURN = 2;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_burn = 1'b0;
  logic [4:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rd_data;
  logic ready, err_pulse;

  int n_tests = 0, n_fail = 0;
  logic [15:0] m_otp [16];
  logic [15:0] m_mir [16];

  always #2.5 clk = ~clk;

  cfg_bank_top #(.CHIP_ID(CHIP_ID)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .req_valid(req_valid),
    .req_write(req_write), .req_burn(req_burn), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .ready(ready), .err_pulse(err_pulse)
  );

  function automatic logic [15:0] power_on_word(int i);
    if (i == 15) return CHIP_ID;
    if (i >= 8)  return {i[3:0], 8'hC3, 4'h1};
    return 16'h0000;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side restatement of the access rules; returns expected refusal
  function automatic bit model_op(int op, logic [4:0] a, logic [15:0] d);
    int  i   = int'(a[3:0]);
    bit  vol = a[4];
    bit  lk  = m_mir[i][15];
    if (op == OP_BURN) begin
      if (i < 8 && !lk && !m_otp[i][0]) begin
        m_otp[i] = m_mir[i] | 16'h0001;
        m_mir[i] = m_otp[i];
        return 1'b0;
      end
      return 1'b1;
    end
    if (op == OP_WRITE) begin
      if (vol && i < 8 && !lk) begin
        m_mir[i] = d;
        return 1'b0;
      end
      return 1'b1;
    end
    return 1'b0;
  endfunction

  // entered and left just after a falling edge
  task automatic do_op(string req, int op, logic [4:0] a, logic [15:0] d);
    bit exp_err;
    req_valid = 1'b1; req_write = (op == OP_WRITE); req_burn = (op == OP_BURN);
    req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_burn = 1'b0;
    exp_err = model_op(op, a, d);
    chk(req, {15'd0, err_pulse}, {15'd0, exp_err});
  endtask

  task automatic check_all(string req);
    for (int a = 0; a < 32; a++) begin
      req_addr = 5'(a);
      #0.1;
      chk(req, rd_data, a < 16 ? m_otp[a] : m_mir[a-16]);
    end
    @(negedge clk);
  endtask

  task automatic wait_load(string req);
    for (int k = 1; k <= 16; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 5'd16; req_wdata = 16'h7777;
      end
      if (k == 3) begin
        req_valid = 1'b0; req_write = 1'b0;
        chk("R1 ignored during load", {15'd0, err_pulse}, 16'd0);
      end
      if (k == 15) chk(req, {15'd0, ready}, 16'd0);
      if (k == 16) chk(req, {15'd0, ready}, 16'd1);
    end
    for (int i = 0; i < 16; i++) m_mir[i] = (i == 15) ? 16'h0000 : m_otp[i];
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h00C0FFEE);
    for (int i = 0; i < 16; i++) begin m_otp[i] = power_on_word(i); m_mir[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 reset ready low", {15'd0, ready}, 16'd0);
    chk("R9 reset no error", {15'd0, err_pulse}, 16'd0);
    por_n = 1'b1; rst_n = 1'b1;
    wait_load("R1 ready timing");
    check_all("R2 R3 loaded contents");
    req_addr = 5'd15; #0.1; chk("R2 identity word", rd_data, CHIP_ID);
    req_addr = 5'd31; #0.1; chk("R2 identity not copied", rd_data, 16'h0000);
    @(negedge clk);

    do_op("R4 write working", OP_WRITE, 5'd17, 16'h1234);
    req_addr = 5'd17; #0.1; chk("R4 readback", rd_data, 16'h1234);
    @(negedge clk);
    do_op("R8 write fuse area", OP_WRITE, 5'd1, 16'hAAAA);
    chk("R9 strobe one cycle", {15'd0, err_pulse}, 16'd1);
    @(negedge clk);
    chk("R9 strobe dropped", {15'd0, err_pulse}, 16'd0);
    do_op("R8 write id area", OP_WRITE, 5'd28, 16'h5555);
    do_op("R6 burn", OP_BURN, 5'd17, 16'h0000);
    do_op("R7 reburn", OP_BURN, 5'd1, 16'h0000);
    do_op("R5 set lock", OP_WRITE, 5'd18, 16'h8042);
    do_op("R5 locked write", OP_WRITE, 5'd18, 16'h0001);
    do_op("R5 locked burn", OP_BURN, 5'd2, 16'h0000);
    do_op("R8 burn id index", OP_BURN, 5'd9, 16'h0000);
    do_op("R10 plain read", OP_READ, 5'd3, 16'hFFFF);
    req_valid = 1'b1; req_write = 1'b1; req_burn = 1'b1; req_addr = 5'd20;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_burn = 1'b0;
    chk("R9 burn priority", {15'd0, err_pulse}, {15'd0, model_op(OP_BURN, 5'd20, 16'h0)});
    check_all("R6 R9 after directed");

    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 2));
      logic [4:0] a = 5'($urandom_range(0, 31));
      logic [15:0] d = 16'($urandom);
      if ($urandom_range(0, 1) == 1) a[3] = 1'b0;
      if ($urandom_range(0, 7) != 0) d[15] = 1'b0;
      do_op("R4 R5 R6 R7 R8 random", op, a, d);
      if (n % 50 == 49) check_all("R3 random sweep");
    end

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_load("R1 reload timing");
    check_all("R2 reload keeps fuses");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule